// File: doc/BRIEF.md
# ADC Result Byte Registers with Coherent Two-Byte Read

This block sits between a 10-bit analog-to-digital converter core and an 8-bit register bus. Whenever the converter signals that a single-channel conversion has finished, the block stores the 10-bit result. It shows the result left aligned across two byte registers: an upper byte carrying result bits 9..2 and a lower byte carrying bits 1..0 in its top two positions.

A processor reading a 10-bit value over an 8-bit bus needs two accesses. If a new conversion landed between them, the two halves would come from different samples. To prevent this, a read of the upper byte arms a lock. While the lock is armed, the stored result is frozen and completed conversions are thrown away. The matching lower-byte read releases the lock.

The block also decodes the 5-bit channel-select field. It drives a one-hot selection for the analog multiplexer and raises separate flags for the power-off code and for unused codes.

Top module: `adc_result_regs`

## Requirements
- R1: A read (rd_en high) at address 0x3D returns result bits 9..2 on rd_data in the cycle after rd_en is sampled.
- R2: A read at address 0x3E returns result bits 1..0 on rd_data[7:6], with rd_data[5:0] zero, in the cycle after rd_en is sampled.
- R3: While the lock is clear, a one-cycle conv_done pulse with a channel code other than 31 stores conv_data as the new result.
- R4: A read at 0x3D arms the lock. While the lock is armed, completed conversions are discarded, not queued, so both bytes keep the value seen at the upper-byte read.
- R5: A read at 0x3E clears the lock, and the next conversion is stored again.
- R6: A read at 0x3E with no prior upper-byte read returns the current value and leaves the lock clear.
- R7: A conversion that completes in the same cycle as an upper-byte read, or in the same cycle as the lower-byte read that releases the lock, is discarded.
- R8: Channel code 31 raises pwr_off and drives sel_onehot to zero, and conv_done is ignored while it is selected.
- R9: Codes 0..23 set sel_onehot bit equal to the code, code 29 sets bit 24 (upper reference), and code 30 sets bit 25 (lower reference). No more than one bit is ever set.
- R10: Codes 24..28 raise chan_invalid with sel_onehot zero and pwr_off low.
- R11: rd_data is zero in the cycle after a cycle with rd_en low, and after a read of any address other than 0x3D and 0x3E.
- R12: Synchronous reset clears the lock and rd_data but leaves the stored result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 5 | Channel-select code |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_data | input | 10 | Conversion result, valid with conv_done |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register byte address |
| rd_data | output | 8 | Registered read data |
| sel_onehot | output | 26 | Analog input select: bits 0..23 inputs, 24 upper reference, 25 lower reference |
| pwr_off | output | 1 | Power-off code selected |
| chan_invalid | output | 1 | Unused channel code selected |

## Verification
The hardest cases to reach are collisions: a conversion strobe that lands in exactly the same clock as the upper-byte read, or as the lower-byte read that releases the lock. The bench drives conv_done and rd_en together on one edge for each collision. It then reads the pair again to show that the colliding sample never reached either byte. The loss of conversions during a lock is shown the same way: several strobes are issued between the two reads, and a second upper-byte read proves that none of them was held back for later.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
    localparam int RES_W   = 10;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int CODE_W  = 5;
    localparam int NUM_IN  = 24;
    localparam int LO_BITS = RES_W - BUS_W;
    localparam int NUM_SEL = NUM_IN + 2;
    localparam int SEL_REFHI = NUM_IN;
    localparam int SEL_REFLO = NUM_IN + 1;

    localparam logic [ADDR_W-1:0] HI_ADDR = 8'h3D;
    localparam logic [ADDR_W-1:0] LO_ADDR = 8'h3E;

    localparam logic [CODE_W-1:0] CODE_REFHI = 5'd29;
    localparam logic [CODE_W-1:0] CODE_REFLO = 5'd30;
    localparam logic [CODE_W-1:0] CODE_OFF   = 5'd31;

    typedef enum logic [1:0] {
        CH_INPUT,
        CH_REF,
        CH_OFF,
        CH_BAD
    } chan_kind_e;

    typedef struct packed {
        chan_kind_e         kind;
        logic [NUM_SEL-1:0] sel;
    } chan_dec_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_HI,
        ACC_LO,
        ACC_OTHER
    } acc_e;

    function automatic logic [BUS_W-1:0] upper_byte(input logic [RES_W-1:0] r);
        return r[RES_W-1 -: BUS_W];
    endfunction

    function automatic logic [BUS_W-1:0] lower_byte(input logic [RES_W-1:0] r);
        return {r[LO_BITS-1:0], {(BUS_W-LO_BITS){1'b0}}};
    endfunction
endpackage

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
    import adc_result_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output chan_dec_t         dec
);
    logic [NUM_IN-1:0] in_hit;
    logic              refhi_hit;
    logic              reflo_hit;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        assign in_hit[g] = (code == CODE_W'(g));
    end

    assign refhi_hit = (code == CODE_REFHI);
    assign reflo_hit = (code == CODE_REFLO);

    always_comb begin
        dec.sel = {reflo_hit, refhi_hit, in_hit};
        if (|in_hit)                     dec.kind = CH_INPUT;
        else if (refhi_hit || reflo_hit) dec.kind = CH_REF;
        else if (code == CODE_OFF)       dec.kind = CH_OFF;
        else                             dec.kind = CH_BAD;
    end
endmodule

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
    import adc_result_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output acc_e              acc
);
    always_comb begin
        if (!rd_en)                 acc = ACC_NONE;
        else if (rd_addr == HI_ADDR) acc = ACC_HI;
        else if (rd_addr == LO_ADDR) acc = ACC_LO;
        else                         acc = ACC_OTHER;
    end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
    import adc_result_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             conv_ok,
    input  acc_e             acc,
    output logic [RES_W-1:0] res_q,
    output logic             locked
);
    logic accept;

    // A sample is taken only when no pair read is in progress and the
    // upper byte is not being read in this very cycle.
    assign accept = conv_done && conv_ok && !locked && (acc != ACC_HI);

    always_ff @(posedge clk) begin
        if (accept) res_q <= conv_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                  locked <= 1'b0;
        else if (acc == ACC_HI)   locked <= 1'b1;
        else if (acc == ACC_LO)   locked <= 1'b0;
    end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_result_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  chan_sel,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BUS_W-1:0]   rd_data,
    output logic [NUM_SEL-1:0] sel_onehot,
    output logic               pwr_off,
    output logic               chan_invalid
);
    chan_dec_t        dec;
    acc_e             acc;
    logic [RES_W-1:0] res_q;
    logic             locked;

    adc_chan_decode u_chan (
        .code (chan_sel),
        .dec  (dec)
    );

    adc_bus_decode u_bus (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .acc     (acc)
    );

    adc_result_store u_store (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .conv_ok   (dec.kind != CH_OFF),
        .acc       (acc),
        .res_q     (res_q),
        .locked    (locked)
    );

    assign sel_onehot   = dec.sel;
    assign pwr_off      = (dec.kind == CH_OFF);
    assign chan_invalid = (dec.kind == CH_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            unique case (acc)
                ACC_HI:  rd_data <= upper_byte(res_q);
                ACC_LO:  rd_data <= lower_byte(res_q);
                default: rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk
    import adc_result_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               conv_done,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [BUS_W-1:0]   rd_data,
    input logic [NUM_SEL-1:0] sel_onehot,
    input logic               pwr_off,
    input logic               chan_invalid,
    input logic               locked,
    input logic [RES_W-1:0]   res_q
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot)); // R9

    AST_BAD_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        chan_invalid |-> (sel_onehot == '0) && !pwr_off); // R10

    AST_OFF_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        pwr_off |-> (sel_onehot == '0)); // R8

    AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (conv_done && pwr_off) |=> $stable(res_q)); // R8

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(res_q)); // R4

    AST_HI_ARMS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == HI_ADDR) |=> locked); // R4

    AST_LO_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == LO_ADDR) |=> !locked); // R5

    AST_LO_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == LO_ADDR) |=> (rd_data[BUS_W-LO_BITS-1:0] == '0)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0)); // R11

    AST_RESET_UNLOCK: assert property (@(posedge clk)
        rst |=> !locked && (rd_data == '0)); // R12
endmodule

bind adc_result_regs adc_result_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_done    (conv_done),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .sel_onehot   (sel_onehot),
    .pwr_off      (pwr_off),
    .chan_invalid (chan_invalid),
    .locked       (locked),
    .res_q        (res_q)
);

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb;
    import adc_result_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [CODE_W-1:0]  chan_sel = '0;
    logic               conv_done = 1'b0;
    logic [RES_W-1:0]   conv_data = '0;
    logic               rd_en = 1'b0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [BUS_W-1:0]   rd_data;
    logic [NUM_SEL-1:0] sel_onehot;
    logic               pwr_off;
    logic               chan_invalid;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    adc_result_regs u_dut (
        .clk          (clk),
        .rst          (rst),
        .chan_sel     (chan_sel),
        .conv_done    (conv_done),
        .conv_data    (conv_data),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .sel_onehot   (sel_onehot),
        .pwr_off      (pwr_off),
        .chan_invalid (chan_invalid)
    );

    // {channel code, conversion data}
    localparam logic [14:0] VEC [0:7] = '{
        {5'd0,  10'h3FF},
        {5'd5,  10'h000},
        {5'd16, 10'h2AA},
        {5'd23, 10'h155},
        {5'd31, 10'h123},
        {5'd29, 10'h201},
        {5'd30, 10'h0FE},
        {5'd26, 10'h37C}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic conv(input logic [CODE_W-1:0] c, input logic [RES_W-1:0] d);
        chan_sel  = c;
        conv_data = d;
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [BUS_W-1:0] v);
        rd_en   = 1'b1;
        rd_addr = a;
        tick();
        rd_en = 1'b0;
        v     = rd_data;
    endtask

    function automatic logic [BUS_W-1:0] exp_hi(input logic [RES_W-1:0] r);
        return r[9:2];
    endfunction

    function automatic logic [BUS_W-1:0] exp_lo(input logic [RES_W-1:0] r);
        return {r[1:0], 6'b0};
    endfunction

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] v;
        logic [RES_W-1:0] model;
        model = '0;

        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        chk("R12 reset rd_data", 32'(rd_data), 32'h0);

        // table walk: store, decode, read pair
        for (int i = 0; i < 8; i++) begin
            logic [CODE_W-1:0]  c;
            logic [RES_W-1:0]   d;
            logic [NUM_SEL-1:0] es;
            c = VEC[i][14:10];
            d = VEC[i][9:0];
            chan_sel = c;
            #1;
            es = '0;
            if (c < 5'd24)       es[c] = 1'b1;
            else if (c == 5'd29) es[24] = 1'b1;
            else if (c == 5'd30) es[25] = 1'b1;
            chk("R9 table sel", 32'(sel_onehot), 32'(es));
            @(negedge clk);
            conv(c, d);
            if (c != 5'd31) model = d;
            rd(HI_ADDR, v);
            chk((c == 5'd31) ? "R8 off ignored hi" : "R1 R3 hi", 32'(v), 32'(exp_hi(model)));
            rd(LO_ADDR, v);
            chk("R2 lo", 32'(v), 32'(exp_lo(model)));
        end

        // decode sweep over all codes
        for (int c = 0; c < 32; c++) begin
            logic [NUM_SEL-1:0] es;
            es = '0;
            if (c < 24)       es[c] = 1'b1;
            else if (c == 29) es[24] = 1'b1;
            else if (c == 30) es[25] = 1'b1;
            chan_sel = 5'(c);
            #1;
            chk("R9 sweep sel", 32'(sel_onehot), 32'(es));
            chk("R10 sweep invalid", 32'(chan_invalid), 32'(c >= 24 && c <= 28));
            chk("R8 sweep pwr_off", 32'(pwr_off), 32'(c == 31));
        end
        @(negedge clk);

        // R4: lock freezes both bytes, conversions dropped not queued
        conv(5'd3, 10'h2C5);
        rd(HI_ADDR, v);
        chk("R4 hi before lock", 32'(v), 32'h0B1);
        conv(5'd3, 10'h111);
        conv(5'd3, 10'h0AB);
        rd(LO_ADDR, v);
        chk("R4 lo frozen", 32'(v), 32'h040);
        rd(HI_ADDR, v);
        chk("R4 not queued", 32'(v), 32'h0B1);
        rd(LO_ADDR, v);

        // R5: released lock accepts the next conversion
        conv(5'd3, 10'h0AB);
        rd(HI_ADDR, v);
        chk("R5 hi after release", 32'(v), 32'h02A);
        rd(LO_ADDR, v);
        chk("R5 lo after release", 32'(v), 32'h0C0);

        // R6: lone low read does not lock
        rd(LO_ADDR, v);
        chk("R6 lone lo", 32'(v), 32'h0C0);
        conv(5'd3, 10'h3C1);
        rd(HI_ADDR, v);
        chk("R6 still unlocked", 32'(v), 32'h0F0);
        rd(LO_ADDR, v);
        chk("R6 lo", 32'(v), 32'h040);

        // R7: conversion colliding with the upper-byte read
        chan_sel  = 5'd3;
        conv_data = 10'h001;
        conv_done = 1'b1;
        rd_en     = 1'b1;
        rd_addr   = HI_ADDR;
        tick();
        conv_done = 1'b0;
        rd_en     = 1'b0;
        chk("R7 hi collision data", 32'(rd_data), 32'h0F0);
        rd(LO_ADDR, v);
        chk("R7 hi collision lo", 32'(v), 32'h040);
        rd(HI_ADDR, v);
        chk("R7 hi collision dropped", 32'(v), 32'h0F0);

        // R7: conversion colliding with the releasing lower-byte read
        conv_data = 10'h002;
        conv_done = 1'b1;
        rd_en     = 1'b1;
        rd_addr   = LO_ADDR;
        tick();
        conv_done = 1'b0;
        rd_en     = 1'b0;
        chk("R7 lo collision data", 32'(rd_data), 32'h040);
        rd(HI_ADDR, v);
        chk("R7 lo collision dropped", 32'(v), 32'h0F0);
        rd(LO_ADDR, v);

        // R11: unmapped addresses and idle cycles
        rd(8'h3C, v);
        chk("R11 addr 3C", 32'(v), 32'h0);
        rd(8'h3F, v);
        chk("R11 addr 3F", 32'(v), 32'h0);
        rd(HI_ADDR, v);
        tick();
        chk("R11 idle zero", 32'(rd_data), 32'h0);
        rd(LO_ADDR, v);

        // R12: reset keeps data, clears the lock
        conv(5'd7, 10'h3A7);
        rd(HI_ADDR, v);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R12 rd_data cleared", 32'(rd_data), 32'h0);
        rd(HI_ADDR, v);
        chk("R12 data kept hi", 32'(v), 32'h0E9);
        rd(LO_ADDR, v);
        chk("R12 data kept lo", 32'(v), 32'h0C0);
        rd(HI_ADDR, v);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        conv(5'd1, 10'h155);
        rd(HI_ADDR, v);
        chk("R12 lock cleared", 32'(v), 32'h055);
        rd(LO_ADDR, v);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule